// File: doc/BRIEF.md
# Escaped extraction word stream decoder

A switch hands frames to its host CPU through an extraction queue that is read one 32-bit word at a time. Some word values are reserved as in-band control codes: an end-of-frame code that also tells how many bytes of the closing word carry data, a pruned variant of it, an abort code, a not-ready code and an escape code. This block sits between the raw queue read port and the frame consumer. It strips the control codes out, unescapes literal words, and produces a clean stream of data beats. Each beat carries a byte count, an end-of-frame mark, a pruned mark and an error mark.

Both sides use a valid/ready handshake. The decoder holds no data registers, so a beat leaves in the same cycle its raw word is taken. A header flag tells the decoder whether the frame header is being read, because that changes what a not-ready word means. After an error, the decoder drains the queue. It takes and discards raw words until the queue's data-present indication drops. Then it waits for the next frame.

Top module: `xq_word_decoder`

## Requirements
- R1: A raw word that is not one of the eight codes 0x80000000 to 0x80000007 is output as one beat with the same data, byte count 4, and the end, pruned and error marks low.
- R2: The escape code 0x80000006 produces no beat. The next raw word is output as data with byte count 4, even when it equals a control code.
- R3: An end-of-frame code 0x80000000 to 0x80000003 produces no beat. The next non-escape, non-not-ready raw word is output with the end mark high and byte count equal to 4 minus the code's low two bits (4, 3, 2, 1).
- R4: The pruned code 0x80000004 acts as an end-of-frame code with byte count 4. Its final beat has both the end mark and the pruned mark high.
- R5: When an escape code follows an end-of-frame or pruned code, the word after the escape is taken literally as the final word, with that frame's byte count and marks.
- R6: The abort code 0x80000005 produces a single beat with the error mark high, data 0, byte count 0 and the end mark low.
- R7: The not-ready code 0x80000007 produces an error beat as in R6 while the header flag is high. While the header flag is low, or while the final word is awaited, it is dropped with no beat.
- R8: After an error beat the decoder accepts raw words whatever the downstream ready is, and discards them, for as long as data-present is high. Once it samples data-present low, it decodes the next word as the start of a frame.
- R9: Outside the drain, raw ready follows downstream ready. A beat is offered only while a raw word is offered, and it is held while downstream is not ready.
- R10: After reset no beat is offered, and decoding starts at a frame boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| raw_valid_i | input | 1 | Raw word offered |
| raw_word_i | input | 32 | Raw word read from the queue |
| raw_ready_o | output | 1 | Raw word taken this cycle when valid |
| hdr_phase_i | input | 1 | Frame header is being read |
| data_present_i | input | 1 | Queue still holds words |
| out_valid_o | output | 1 | Beat offered |
| out_ready_i | input | 1 | Downstream accepts a beat |
| out_data_o | output | 32 | Beat data |
| out_bytes_o | output | 3 | Valid bytes in the beat (0 for error beats) |
| out_eof_o | output | 1 | Final beat of the frame |
| out_pruned_o | output | 1 | Frame was pruned |
| out_err_o | output | 1 | Frame aborted or header read failed |

## Verification
The decoder is fed plain words, including values that sit just outside the reserved code range. This separates real codes from near misses. Escaped control codes are sent in the body and after each end code. These show whether the word after an escape is ever decoded as a code. All four end codes and the pruned code are tried, which exercises every byte count. The not-ready code is sent with the header flag both high and low, which separates waiting from failing. An abort is followed by junk words sent while downstream is stalled, then data-present is dropped. This shows that the drain swallows words without emitting beats, and that it ends only on the data-present condition.

// File: rtl/xq_dec_pkg.sv
package xq_dec_pkg;
  typedef enum logic [2:0] {
    K_DATA, K_EOF, K_PRUNE, K_ABORT, K_ESC, K_NRDY
  } word_kind_e;

  typedef enum logic [2:0] {
    S_IDLE, S_DATA, S_ESC, S_LAST, S_LAST_ESC, S_FLUSH
  } dec_state_e;

  // control code offsets above the top-bit base
  localparam int unsigned OFS_PRUNE = 4;
  localparam int unsigned OFS_ABORT = 5;
  localparam int unsigned OFS_ESC   = 6;
  localparam int unsigned OFS_NRDY  = 7;
endpackage

// File: rtl/xq_word_class.sv
module xq_word_class
  import xq_dec_pkg::*;
#(
  parameter int unsigned WORD_W = 32,
  localparam int unsigned NBYTES = WORD_W / 8,
  localparam int unsigned BYTES_W = $clog2(NBYTES + 1),
  localparam int unsigned LOW_W = $clog2(NBYTES)
) (
  input  logic [WORD_W-1:0]  word_i,
  output word_kind_e         kind_o,
  output logic [BYTES_W-1:0] code_bytes_o
);
  localparam logic [WORD_W-1:0] BASE = {1'b1, {(WORD_W-1){1'b0}}};

  logic [WORD_W-1:0] ofs;
  assign ofs = word_i - BASE;

  always_comb begin
    kind_o = K_DATA;
    if (word_i[WORD_W-1] && ofs < WORD_W'(8)) begin
      if (ofs < WORD_W'(NBYTES))       kind_o = K_EOF;
      else if (ofs == WORD_W'(OFS_PRUNE)) kind_o = K_PRUNE;
      else if (ofs == WORD_W'(OFS_ABORT)) kind_o = K_ABORT;
      else if (ofs == WORD_W'(OFS_ESC))   kind_o = K_ESC;
      else                                kind_o = K_NRDY;
    end
  end

  assign code_bytes_o = BYTES_W'(NBYTES) - BYTES_W'(word_i[LOW_W-1:0]);
endmodule

// File: rtl/xq_dec_fsm.sv
module xq_dec_fsm
  import xq_dec_pkg::*;
#(
  parameter int unsigned BYTES_W = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               fire_i,
  input  word_kind_e         kind_i,
  input  logic [BYTES_W-1:0] code_bytes_i,
  input  logic               hdr_phase_i,
  input  logic               data_present_i,
  output dec_state_e         state_o,
  output logic               emit_o,
  output logic               last_o,
  output logic               err_o,
  output logic [BYTES_W-1:0] last_bytes_o,
  output logic               last_pruned_o
);
  dec_state_e st_q, st_d;
  logic [BYTES_W-1:0] bytes_q;
  logic pruned_q;

  always_comb begin
    st_d   = st_q;
    emit_o = 1'b0;
    last_o = 1'b0;
    err_o  = 1'b0;
    unique case (st_q)
      S_IDLE, S_DATA: begin
        unique case (kind_i)
          K_ESC:          st_d = S_ESC;
          K_EOF, K_PRUNE: st_d = S_LAST;
          K_ABORT: begin
            emit_o = 1'b1; err_o = 1'b1; st_d = S_FLUSH;
          end
          K_NRDY: if (hdr_phase_i) begin
            emit_o = 1'b1; err_o = 1'b1; st_d = S_FLUSH;
          end
          default: begin
            emit_o = 1'b1; st_d = S_DATA;
          end
        endcase
      end
      S_ESC: begin
        emit_o = 1'b1; st_d = S_DATA;
      end
      S_LAST: begin
        if (kind_i == K_ESC) st_d = S_LAST_ESC;
        else if (kind_i != K_NRDY) begin
          emit_o = 1'b1; last_o = 1'b1; st_d = S_IDLE;
        end
      end
      S_LAST_ESC: begin
        emit_o = 1'b1; last_o = 1'b1; st_d = S_IDLE;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= S_IDLE;
      bytes_q  <= '0;
      pruned_q <= 1'b0;
    end else if (st_q == S_FLUSH) begin
      if (!data_present_i) st_q <= S_IDLE;
    end else if (fire_i) begin
      st_q <= st_d;
      if ((st_q == S_IDLE || st_q == S_DATA) && (kind_i == K_EOF || kind_i == K_PRUNE)) begin
        bytes_q  <= code_bytes_i;
        pruned_q <= (kind_i == K_PRUNE);
      end
    end
  end

  assign state_o       = st_q;
  assign last_bytes_o  = bytes_q;
  assign last_pruned_o = pruned_q;
endmodule

// File: rtl/xq_beat_form.sv
module xq_beat_form #(
  parameter int unsigned WORD_W = 32,
  localparam int unsigned NBYTES = WORD_W / 8,
  localparam int unsigned BYTES_W = $clog2(NBYTES + 1)
) (
  input  logic [WORD_W-1:0]  word_i,
  input  logic               last_i,
  input  logic               err_i,
  input  logic [BYTES_W-1:0] last_bytes_i,
  input  logic               last_pruned_i,
  output logic [WORD_W-1:0]  data_o,
  output logic [BYTES_W-1:0] bytes_o,
  output logic               eof_o,
  output logic               pruned_o,
  output logic               err_o
);
  always_comb begin
    data_o   = err_i ? '0 : word_i;
    bytes_o  = err_i ? '0 : (last_i ? last_bytes_i : BYTES_W'(NBYTES));
    eof_o    = last_i;
    pruned_o = last_i & last_pruned_i;
    err_o    = err_i;
  end
endmodule

// File: rtl/xq_word_decoder.sv
module xq_word_decoder
  import xq_dec_pkg::*;
#(
  parameter int unsigned WORD_W = 32,
  localparam int unsigned NBYTES = WORD_W / 8,
  localparam int unsigned BYTES_W = $clog2(NBYTES + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               raw_valid_i,
  input  logic [WORD_W-1:0]  raw_word_i,
  output logic               raw_ready_o,
  input  logic               hdr_phase_i,
  input  logic               data_present_i,
  output logic               out_valid_o,
  input  logic               out_ready_i,
  output logic [WORD_W-1:0]  out_data_o,
  output logic [BYTES_W-1:0] out_bytes_o,
  output logic               out_eof_o,
  output logic               out_pruned_o,
  output logic               out_err_o
);
  word_kind_e kind;
  dec_state_e state;
  logic [BYTES_W-1:0] code_bytes, last_bytes;
  logic emit, last, err, last_pruned, fire;

  xq_word_class #(.WORD_W(WORD_W)) u_class (
    .word_i(raw_word_i), .kind_o(kind), .code_bytes_o(code_bytes)
  );

  xq_dec_fsm #(.BYTES_W(BYTES_W)) u_fsm (
    .clk_i, .rst_ni, .fire_i(fire), .kind_i(kind), .code_bytes_i(code_bytes),
    .hdr_phase_i, .data_present_i, .state_o(state), .emit_o(emit),
    .last_o(last), .err_o(err), .last_bytes_o(last_bytes),
    .last_pruned_o(last_pruned)
  );

  xq_beat_form #(.WORD_W(WORD_W)) u_form (
    .word_i(raw_word_i), .last_i(last), .err_i(err),
    .last_bytes_i(last_bytes), .last_pruned_i(last_pruned),
    .data_o(out_data_o), .bytes_o(out_bytes_o), .eof_o(out_eof_o),
    .pruned_o(out_pruned_o), .err_o(out_err_o)
  );

  // drain ignores downstream back-pressure
  assign raw_ready_o = (state == S_FLUSH) | out_ready_i;
  assign out_valid_o = raw_valid_i & emit;
  assign fire        = raw_valid_i & raw_ready_o;

  a_r1_full_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_eof_o && !out_err_o) |-> out_bytes_o == BYTES_W'(NBYTES));
  a_r3_last_bytes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_eof_o) |-> (out_bytes_o != 0 && out_bytes_o <= BYTES_W'(NBYTES)));
  a_r6_err_clean: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_err_o) |-> (!out_eof_o && out_bytes_o == 0));
  a_r8_err_drains: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && out_err_o) |=> raw_ready_o);
  a_r8_drain_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == S_FLUSH) |-> !out_valid_o);
  a_r9_no_beat_unready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (raw_ready_o && !out_ready_i) |-> !out_valid_o);
  a_r9_beat_needs_raw: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> raw_valid_i);
endmodule

// File: tb/tb_xq_word_decoder.sv
module tb_xq_word_decoder;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic raw_valid = 0, hdr = 0, dp = 1, o_rdy = 1;
  logic [31:0] raw_word = '0;
  logic raw_ready, o_valid, o_eof, o_pruned, o_err;
  logic [31:0] o_data;
  logic [2:0] o_bytes;

  int checks = 0, fails = 0;

  typedef struct {
    logic [31:0] d; logic [2:0] b; logic eof; logic pr; logic er; string tag;
  } beat_t;
  beat_t exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  xq_word_decoder dut (
    .clk_i(clk), .rst_ni(rst_n), .raw_valid_i(raw_valid), .raw_word_i(raw_word),
    .raw_ready_o(raw_ready), .hdr_phase_i(hdr), .data_present_i(dp),
    .out_valid_o(o_valid), .out_ready_i(o_rdy), .out_data_o(o_data),
    .out_bytes_o(o_bytes), .out_eof_o(o_eof), .out_pruned_o(o_pruned),
    .out_err_o(o_err)
  );

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [31:0] d, input logic [2:0] b, input logic eof,
                      input logic pr, input logic er, input string tag);
    beat_t x;
    x.d = d; x.b = b; x.eof = eof; x.pr = pr; x.er = er; x.tag = tag;
    exp_q.push_back(x);
  endtask

  task automatic send(input logic [31:0] w, input logic h);
    raw_word = w; hdr = h; raw_valid = 1;
    do @(negedge clk); while (!raw_ready);
    @(posedge clk); #1 raw_valid = 0;
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && o_valid && o_rdy) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "unexpected beat (R2/R3/R7/R8)", o_data, 32'h0);
      end else begin
        beat_t e;
        e = exp_q.pop_front();
        chk(o_data == e.d, {e.tag, " data"}, o_data, e.d);
        chk({o_bytes, o_eof, o_pruned, o_err} == {e.b, e.eof, e.pr, e.er},
            {e.tag, " bytes/eof/pruned/err"},
            32'({o_bytes, o_eof, o_pruned, o_err}), 32'({e.b, e.eof, e.pr, e.er}));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(o_valid == 0, "R10 reset no beat", 32'(o_valid), 0);
    @(posedge clk); #1 rst_n = 1;

    // R10: first word after reset is frame start, R1 plain words
    push(32'h12345678, 4, 0, 0, 0, "R10"); send(32'h12345678, 1);
    push(32'hdeadbeef, 4, 0, 0, 0, "R1"); send(32'hdeadbeef, 1);
    push(32'h7fffffff, 4, 0, 0, 0, "R1"); send(32'h7fffffff, 0);
    push(32'h80000008, 4, 0, 0, 0, "R1"); send(32'h80000008, 0);
    push(32'hffffffff, 4, 0, 0, 0, "R1"); send(32'hffffffff, 0);

    // R2: escaped control codes
    send(32'h80000006, 0);
    push(32'h80000005, 4, 0, 0, 0, "R2"); send(32'h80000005, 0);
    send(32'h80000006, 0);
    push(32'h80000006, 4, 0, 0, 0, "R2"); send(32'h80000006, 0);
    send(32'h80000006, 0);
    push(32'h80000001, 4, 0, 0, 0, "R2"); send(32'h80000001, 0);

    // R3: each end code
    for (int k = 0; k < 4; k++) begin
      push(32'hA0000000 + k, 4, 0, 0, 0, "R1");
      send(32'hA0000000 + k, 0);
      send(32'h80000000 + k, 0);
      push(32'hB0000000 + k, 3'(4 - k), 1, 0, 0, "R3");
      send(32'hB0000000 + k, 0);
    end

    // R4: pruned
    send(32'h80000004, 0);
    push(32'h0badf00d, 4, 1, 1, 0, "R4"); send(32'h0badf00d, 0);

    // R5: escape after end code
    send(32'h80000002, 0);
    send(32'h80000006, 0);
    push(32'h80000007, 2, 1, 0, 0, "R5"); send(32'h80000007, 0);
    send(32'h80000004, 0);
    send(32'h80000006, 0);
    push(32'h80000006, 4, 1, 1, 0, "R5"); send(32'h80000006, 0);

    // R7: not-ready dropped in payload and while awaiting final word
    send(32'h80000007, 0);
    push(32'h11112222, 4, 0, 0, 0, "R7"); send(32'h11112222, 0);
    send(32'h80000003, 0);
    send(32'h80000007, 1);
    push(32'h33334444, 1, 1, 0, 0, "R7"); send(32'h33334444, 0);

    // R7: not-ready in header is an error
    push(32'h0, 0, 0, 0, 1, "R7"); send(32'h80000007, 1);
    dp = 0; @(posedge clk); #1 dp = 1;

    // R6 abort, then R8 drain with downstream stalled
    push(32'h55556666, 4, 0, 0, 0, "R1"); send(32'h55556666, 0);
    push(32'h0, 0, 0, 0, 1, "R6"); send(32'h80000005, 0);
    o_rdy = 0;
    @(negedge clk);
    chk(raw_ready == 1, "R8 ready while draining", 32'(raw_ready), 1);
    send(32'h99990000, 0);
    send(32'h80000003, 0);
    send(32'h80000006, 0);
    send(32'h77778888, 0);
    @(negedge clk);
    chk(o_valid == 0 && raw_ready == 1, "R8 still draining", 32'({o_valid, raw_ready}), 1);
    @(posedge clk); #1 dp = 0;
    @(posedge clk); #1 dp = 1;
    @(negedge clk);
    chk(raw_ready == 0, "R9 ready follows downstream after drain", 32'(raw_ready), 0);
    @(posedge clk); #1 o_rdy = 1;
    push(32'hCAFE0001, 4, 0, 0, 0, "R8"); send(32'hCAFE0001, 1);

    // R9: beat held under back-pressure
    #0 o_rdy = 0; raw_word = 32'h24682468; hdr = 0; raw_valid = 1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(o_valid == 1 && raw_ready == 0, "R9 stall", 32'({o_valid, raw_ready}), 32'b10);
    end
    push(32'h24682468, 4, 0, 0, 0, "R9");
    @(posedge clk); #1 o_rdy = 1;
    @(posedge clk); #1 raw_valid = 0;
    @(negedge clk);
    chk(o_valid == 0, "R9 no beat without raw word", 32'(o_valid), 0);

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R1 scoreboard drained", exp_q.size(), 0);
    summary();
  end
endmodule